// File: doc/BRIEF.md
# Streaming cell greeting rewriter

This block sits inline on a 32-bit word-serial cell stream. A start-of-cell strobe marks each cell's header word. A flow-control flag travels with the data. The block looks at cells on one virtual channel, which is taken from a field of the header word. If the payload of such a cell starts with the ASCII text "HELLO", the block overwrites the bytes that follow it with "WORLD.". Every other cell leaves the block exactly as it entered.

Each cell is a fixed number of contiguous words. Word 0 is the header and word 1 is a spare word that the block never inspects. The payload begins at word 2. A word counter starts at the strobe and tracks the position in the cell. A small state machine chooses one of four sources for each output word: the live input, two constant replacement words, or zero. The data, strobe and flag outputs are all registered, so every output lags its input by exactly one clock.

Top module: `cell_str_rewrite`

## Requirements
- R1: `soc_o` and `fc_o` equal `soc_i` and `fc_i` of the previous clock. The flow-control flag is never modified.
- R2: While `rst_ni` is low, `data_o`, `soc_o` and `fc_o` are zero, and the decoder returns to its idle state.
- R3: A cell is selected only if its header word has bits 19:4 equal to `CH_ID` (default 0x0005). Any other value lets the whole cell through unchanged.
- R4: The header word (index 0) and the word after it (index 1) are always output unchanged. Index 1 is never compared.
- R5: Index 2 must be exactly 0x48454C4C ("HELL"). If it is not, the whole cell is output unchanged.
- R6: Index 3 must have 0x4F ("O") in bits 31:24. If it does, index 3 is output as 0x4F574F52. If it does not, index 3 and the rest of the cell are output unchanged.
- R7: After a full match, index 4 is output as 0x4C442E00, and indexes 5 up to `CELL_WORDS`-1 are output unchanged.
- R8: A cell is `CELL_WORDS` words long (default 14), counted from the strobe. After the last word, any word that arrives without a strobe is output as zero.
- R9: A strobe on the clock right after a cell's last word starts decoding the new cell at once, with no idle gap.
- R10: A strobe at any point inside a cell abandons that cell and takes the strobed word as a new header.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 32 | Incoming cell word |
| soc_i | input | 1 | Start-of-cell strobe, marks the header word |
| fc_i | input | 1 | Flow-control flag travelling with the data |
| data_o | output | 32 | Registered output word, possibly rewritten |
| soc_o | output | 1 | Registered start-of-cell strobe |
| fc_o | output | 1 | Registered flow-control flag |

## Verification
The bench runs near-miss cells against a clean match:
- A wrong channel, which a filter looking at the wrong bit field would rewrite.
- "MELL" in place of "HELL".
- "HELL" followed by a wrong fifth byte, which a design that commits after the first payload word would corrupt.

It sends two cells back to back to catch a counter that is off by one, which would either swallow the second strobe or zero its header. It also cuts a matched cell short with a fresh strobe. A design that ignores strobes mid-cell would keep the old cell's state and miss or corrupt the new one. Idle words between cells must come out as zero. This exposes a design that leaves its counter running or never returns to idle.

// File: rtl/cell_rw_pkg.sv
package cell_rw_pkg;
  localparam int unsigned DATA_W = 32;

  localparam logic [DATA_W-1:0] MATCH_WORD = 32'h4845_4C4C; // "HELL"
  localparam logic [7:0]        MATCH_BYTE = 8'h4F;         // "O"
  localparam logic [DATA_W-1:0] REP_WORD_A = 32'h4F57_4F52; // "OWOR"
  localparam logic [DATA_W-1:0] REP_WORD_B = 32'h4C44_2E00; // "LD.\0"

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PAD,
    ST_HELL,
    ST_OCHK,
    ST_TAIL,
    ST_PASS
  } st_e;

  typedef enum logic [1:0] {
    SEL_PASS,
    SEL_REP_A,
    SEL_REP_B,
    SEL_ZERO
  } sel_e;
endpackage

// File: rtl/cell_rw_counter.sv
module cell_rw_counter #(
  parameter int unsigned CELL_WORDS = 14,
  localparam int unsigned CNT_W = $clog2(CELL_WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CELL_WORDS - 1);

  logic [CNT_W-1:0] cnt_q;

  // cnt_q holds the index of the word currently on data_i (when not strobed)
  assign last_o = en_i && !load_i && (cnt_q == LAST_IDX);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (load_i)   cnt_q <= CNT_W'(1);
    else if (last_o)   cnt_q <= '0;
    else if (en_i)     cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/cell_rw_fsm.sv
module cell_rw_fsm
  import cell_rw_pkg::*;
#(
  parameter int unsigned CH_LSB = 4,
  parameter int unsigned CH_W   = 16,
  parameter logic [CH_W-1:0] CH_ID = 16'h0005
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soc_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              last_i,
  output st_e               st_o,
  output sel_e              sel_o
);
  st_e st_q, st_d;
  logic ch_hit, o_hit;

  assign ch_hit = (data_i[CH_LSB +: CH_W] == CH_ID);
  assign o_hit  = (data_i[DATA_W-1 -: 8] == MATCH_BYTE);

  always_comb begin
    st_d = st_q;
    if (soc_i) begin
      st_d = ch_hit ? ST_PAD : ST_PASS;
    end else if (last_i) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: st_d = ST_IDLE;
        ST_PAD:  st_d = ST_HELL;
        ST_HELL: st_d = (data_i == MATCH_WORD) ? ST_OCHK : ST_PASS;
        ST_OCHK: st_d = o_hit ? ST_TAIL : ST_PASS;
        ST_TAIL: st_d = ST_PASS;
        ST_PASS: st_d = ST_PASS;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  // output source for the word on data_i now
  always_comb begin
    sel_o = SEL_PASS;
    if (!soc_i) begin
      unique case (st_q)
        ST_IDLE: sel_o = SEL_ZERO;
        ST_OCHK: sel_o = o_hit ? SEL_REP_A : SEL_PASS;
        ST_TAIL: sel_o = SEL_REP_B;
        default: sel_o = SEL_PASS;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign st_o = st_q;
endmodule

// File: rtl/cell_rw_mux.sv
module cell_rw_mux
  import cell_rw_pkg::*;
(
  input  sel_e              sel_i,
  input  logic [DATA_W-1:0] live_i,
  output logic [DATA_W-1:0] word_o
);
  always_comb begin
    unique case (sel_i)
      SEL_PASS:  word_o = live_i;
      SEL_REP_A: word_o = REP_WORD_A;
      SEL_REP_B: word_o = REP_WORD_B;
      default:   word_o = '0;
    endcase
  end
endmodule

// File: rtl/cell_str_rewrite.sv
module cell_str_rewrite
  import cell_rw_pkg::*;
#(
  parameter int unsigned CELL_WORDS = 14, // must be >= 5
  parameter int unsigned CH_LSB     = 4,
  parameter int unsigned CH_W       = 16,
  parameter logic [CH_W-1:0] CH_ID  = 16'h0005
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] data_i,
  input  logic        soc_i,
  input  logic        fc_i,
  output logic [31:0] data_o,
  output logic        soc_o,
  output logic        fc_o
);
  localparam int unsigned CNT_W = $clog2(CELL_WORDS);

  st_e              st_q;
  sel_e             sel;
  logic [CNT_W-1:0] cnt_q;
  logic             last;
  logic [31:0]      word_d;

  cell_rw_counter #(.CELL_WORDS(CELL_WORDS)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (soc_i),
    .en_i   (st_q != ST_IDLE),
    .cnt_o  (cnt_q),
    .last_o (last)
  );

  cell_rw_fsm #(.CH_LSB(CH_LSB), .CH_W(CH_W), .CH_ID(CH_ID)) u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .soc_i  (soc_i),
    .data_i (data_i),
    .last_i (last),
    .st_o   (st_q),
    .sel_o  (sel)
  );

  cell_rw_mux u_mux (
    .sel_i  (sel),
    .live_i (data_i),
    .word_o (word_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      soc_o  <= 1'b0;
      fc_o   <= 1'b0;
    end else begin
      data_o <= word_d;
      soc_o  <= soc_i;
      fc_o   <= fc_i;
    end
  end
endmodule

// File: rtl/cell_str_rewrite_chk.sv
module cell_str_rewrite_chk
  import cell_rw_pkg::*;
#(
  parameter int unsigned CELL_WORDS = 14,
  parameter int unsigned CH_LSB     = 4,
  parameter int unsigned CH_W       = 16,
  parameter logic [CH_W-1:0] CH_ID  = 16'h0005,
  localparam int unsigned CNT_W = $clog2(CELL_WORDS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [31:0]      data_i,
  input logic             soc_i,
  input logic             fc_i,
  input logic [31:0]      data_o,
  input logic             soc_o,
  input logic             fc_o,
  input st_e              st_q,
  input logic [CNT_W-1:0] cnt_q
);
  // R1
  soc_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soc_i |=> soc_o);
  // R1
  soc_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !soc_i |=> !soc_o);
  // R1
  fc_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fc_i |=> fc_o);
  // R1
  fc_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fc_i |=> !fc_o);
  // R4
  header_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soc_i |=> data_o == $past(data_i));
  // R3
  chan_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soc_i && (data_i[CH_LSB +: CH_W] != CH_ID) |=> st_q == ST_PASS);
  // R7
  tail_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_TAIL && !soc_i |=> data_o == REP_WORD_B);
  // R8
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_IDLE && !soc_i |=> data_o == '0);
  // R8
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q != ST_IDLE |-> cnt_q <= CNT_W'(CELL_WORDS - 1));
  // R9
  cell_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q != ST_IDLE && !soc_i && cnt_q == CNT_W'(CELL_WORDS - 1) |=> st_q == ST_IDLE);
endmodule

bind cell_str_rewrite cell_str_rewrite_chk #(
  .CELL_WORDS(CELL_WORDS), .CH_LSB(CH_LSB), .CH_W(CH_W), .CH_ID(CH_ID)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .data_i (data_i),
  .soc_i  (soc_i),
  .fc_i   (fc_i),
  .data_o (data_o),
  .soc_o  (soc_o),
  .fc_o   (fc_o),
  .st_q   (st_q),
  .cnt_q  (cnt_q)
);

// File: tb/cell_str_rewrite_tb.sv
module cell_str_rewrite_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NWORDS     = 14;
  localparam logic [15:0] CH = 16'h0005;
  localparam logic [31:0] HELL = 32'h4845_4C4C;
  localparam logic [31:0] RA   = 32'h4F57_4F52;
  localparam logic [31:0] RB   = 32'h4C44_2E00;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [31:0] data_i = '0;
  logic soc_i = 1'b0, fc_i = 1'b0;
  logic [31:0] data_o;
  logic soc_o, fc_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cell_str_rewrite u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .data_i(data_i), .soc_i(soc_i), .fc_i(fc_i),
    .data_o(data_o), .soc_o(soc_o), .fc_o(fc_o)
  );

  task automatic chk32(input string req, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one word at a falling edge, check the registered result one edge later
  task automatic drive_word(input logic [31:0] d, input logic s, f,
                            input logic [31:0] exp, input string req);
    data_i = d; soc_i = s; fc_i = f;
    @(posedge clk_i);
    @(negedge clk_i);
    chk32(req, data_o, exp);
    chk32("R1", {31'd0, soc_o}, {31'd0, s});
    chk32("R1", {31'd0, fc_o}, {31'd0, f});
  endtask

  function automatic logic [31:0] cell_word(input int i, input logic [15:0] ch,
                                            input logic [31:0] w2, w3);
    case (i)
      0: return {12'hABC, ch, 4'h7};
      1: return 32'hE200_0000;
      2: return w2;
      3: return w3;
      default: return 32'h0000_0030 + 32'(i);
    endcase
  endfunction

  // send nw words of a cell; expected output derived from R3..R7
  task automatic send_cell(input logic [15:0] ch, input logic [31:0] w2, w3,
                           input int nw, input string req);
    bit hit;
    hit = (ch == CH) && (w2 == HELL) && (w3[31:24] == 8'h4F);
    for (int i = 0; i < nw; i++) begin
      logic [31:0] w, e;
      string r;
      w = cell_word(i, ch, w2, w3);
      e = w;
      r = req;
      if (i <= 1) r = "R4";
      if (i == 3) begin r = "R6"; if (hit) e = RA; end
      if (i == 4) begin r = "R7"; if (hit) e = RB; end
      drive_word(w, i == 0, (i % 3) == 1, e, r);
    end
  endtask

  task automatic idle_words(input int n);
    for (int i = 0; i < n; i++)
      drive_word(32'hDEAD_0000 + 32'(i), 1'b0, i[0], 32'h0, "R8");
  endtask

  task automatic t_reset;
    data_i = 32'hFFFF_FFFF; soc_i = 1'b1; fc_i = 1'b1;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk32("R2", data_o, 32'h0);
    chk32("R2", {30'd0, soc_o, fc_o}, 32'h0);
    data_i = '0; soc_i = 1'b0; fc_i = 1'b0;
    rst_ni = 1'b1;
    idle_words(2); // decoder idle after reset
  endtask

  task automatic t_match;      send_cell(CH, HELL, 32'h4F00_0000, NWORDS, "R7"); idle_words(2); endtask
  task automatic t_match_low;  send_cell(CH, HELL, 32'h4F12_3456, NWORDS, "R6"); idle_words(1); endtask
  task automatic t_wrong_ch;   send_cell(16'h0004, HELL, 32'h4F00_0000, NWORDS, "R3");
                               send_cell(16'h8005, HELL, 32'h4F00_0000, NWORDS, "R3"); idle_words(1); endtask
  task automatic t_mello;      send_cell(CH, 32'h4D45_4C4C, 32'h4F00_0000, NWORDS, "R5"); idle_words(1); endtask
  task automatic t_bad_o;      send_cell(CH, HELL, 32'h5000_0000, NWORDS, "R6"); idle_words(1); endtask
  task automatic t_back2back;  send_cell(CH, HELL, 32'h4F00_0000, NWORDS, "R9");
                               send_cell(CH, HELL, 32'h4F00_0000, NWORDS, "R9");
                               send_cell(16'h0006, HELL, 32'h4F00_0000, NWORDS, "R9"); idle_words(2); endtask
  task automatic t_restart;    send_cell(CH, HELL, 32'h4F00_0000, 6, "R10");
                               send_cell(CH, HELL, 32'h4F00_0000, NWORDS, "R10");
                               send_cell(CH, HELL, 32'h4F00_0000, 3, "R10");
                               send_cell(CH, 32'h4845_4C4D, 32'h4F00_0000, NWORDS, "R10");
                               idle_words(3); endtask

  initial begin
    @(negedge clk_i);
    t_reset();
    t_match();
    t_match_low();
    t_wrong_ch();
    t_mello();
    t_bad_o();
    t_back2back();
    t_restart();
    done = 1;
  end

  initial begin
    for (int c = 0; c < 200000 && !done; c++) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule